// File: doc/BRIEF.md
# Line Interface Interrupt Status Register

This block collects the event sources of a telephone line-interface controller into one read-only 8-bit status word and drives a single level interrupt towards the host. Four bits report internal conditions: the threshold comparison of the level meter, the readiness of the ramp generator, a flag recording that a reset took place, and the completion of a level-metering run. The remaining four bits carry the debounced general-purpose input pins after a two-stage synchronizer.

Every source has its own trigger rule. Metering completion and ramp readiness interrupt only on a rising edge. The input pins interrupt on a change in either direction unless their mask bit is set. The threshold result never interrupts. The reset flag is set by a hardware reset, and the interrupt is raised at the same moment. The host reads the status word whenever it likes. It acknowledges the interrupt with a single strobe that stands for the full read of all status registers. That strobe drops the interrupt and clears the reset flag. An event that arrives in the same cycle as the strobe is not lost.

Top module: `lineIrqStatus`

## Requirements
- R1: While reset is held and in the first cycle after it, statusOut reads 8'h20 (only bit 5 set) and irqOut is 1.
- R2: Bit 7 of statusOut equals meterAbove as sampled at the previous clock edge (1 = result above threshold, 0 = below). A change on this bit never raises irqOut.
- R3: Bit 4 of statusOut equals meterDone as sampled at the previous clock edge. A 0-to-1 change raises irqOut at that same edge. A 1-to-0 change does not raise it.
- R4: Bit 6 of statusOut is rampReady AND NOT rampStart, sampled at the previous clock edge, so a ramp start forces it to 0. Its 0-to-1 change raises irqOut at that same edge.
- R5: Bits 3:0 of statusOut show pinIn[3:0] (bit n = pin n+1) delayed by two clock edges. A change in either direction of an unmasked pin raises irqOut at the edge where the change reaches statusOut.
- R6: A pin whose pinMask bit is 1 still updates its status bit, but its changes do not raise irqOut.
- R7: A clock edge with rdAck high clears bit 5 of statusOut for good, and also clears irqOut unless a qualifying event occurs at that edge.
- R8: A qualifying event at the same edge as rdAck leaves irqOut at 1 after that edge.
- R9: Once set, irqOut stays at 1 on every edge where rdAck is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| pinIn | input | 4 | Debounced general-purpose input pins, asynchronous |
| pinMask | input | 4 | Per-pin interrupt mask, 1 = pin change ignored |
| meterDone | input | 1 | Level-metering run finished |
| meterAbove | input | 1 | Metering result above the programmed threshold |
| rampReady | input | 1 | Ramp generator idle |
| rampStart | input | 1 | New ramp start command, forces the ready bit to 0 |
| rdAck | input | 1 | Acknowledge strobe standing for the full status read |
| statusOut | output | 8 | Status word {threshold, rampReady, resetFlag, meterDone, pins[3:0]} |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The collision that matters is an acknowledge strobe landing at the same edge as a fresh qualifying event. The clearing path and the setting path then compete for the interrupt flop. A directed case raises meterDone in the very cycle rdAck is pulsed. It expects irqOut to stay at 1 while the reset flag still clears. The random phase pulses rdAck often, alongside frequent pin, ramp and metering toggles, so the same collision recurs with every source. Each cycle is judged against a bench model built from the requirements.

// File: rtl/lineIrqPkg.sv
package lineIrqPkg;

  // Source indications reported by the datapath to the control
  typedef struct packed {
    logic pinChg;     // unmasked pin about to change its visible value
    logic meterRise;  // metering done going 0 -> 1 at this edge
    logic rampRise;   // ramp ready going 0 -> 1 at this edge
  } srcEvt_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clearRst;   // drop the reset-status flag
  } ctrlStrobe_t;

endpackage

// File: rtl/lineIrqSync.sv
module lineIrqSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] nextVal,
  output logic [WIDTH-1:0] curVal
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign nextVal = chain[LAST-1];
  assign curVal  = chain[LAST];

endmodule

// File: rtl/lineIrqDatapath.sv
module lineIrqDatapath
  import lineIrqPkg::*;
#(
  parameter int PIN_COUNT   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int STATUS_W   = PIN_COUNT + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] pinMask,
  input  logic                 meterDone,
  input  logic                 meterAbove,
  input  logic                 rampReady,
  input  logic                 rampStart,
  input  ctrlStrobe_t          strobe,
  output srcEvt_t              srcEvt,
  output logic [STATUS_W-1:0]  statusWord
);

  logic [PIN_COUNT-1:0] pinNext;
  logic [PIN_COUNT-1:0] pinCur;
  logic meterBit, threshBit, rampBit, rstBit;
  logic rampNext;

  lineIrqSync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_pinSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .nextVal (pinNext),
    .curVal  (pinCur)
  );

  assign rampNext = rampReady & ~rampStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meterBit  <= 1'b0;
      threshBit <= 1'b0;
      rampBit   <= 1'b0;
      rstBit    <= 1'b1;
    end else begin
      meterBit  <= meterDone;
      threshBit <= meterAbove;
      rampBit   <= rampNext;
      if (strobe.clearRst) rstBit <= 1'b0;
    end
  end

  always_comb begin
    srcEvt.pinChg    = |((pinNext ^ pinCur) & ~pinMask);
    srcEvt.meterRise = meterDone & ~meterBit;
    srcEvt.rampRise  = rampNext & ~rampBit;
  end

  assign statusWord = {threshBit, rampBit, rstBit, meterBit, pinCur};

  // Once cleared, the reset flag stays clear until the next hardware reset
  assert_rst_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rstBit |=> !rstBit);

  // A ramp start forces the ready bit low at the following edge
  assert_ramp_start_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    rampStart |=> !statusWord[PIN_COUNT+2]);

  // Masked pins never signal an event
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&pinMask) |-> !srcEvt.pinChg);

endmodule

// File: rtl/lineIrqControl.sv
module lineIrqControl
  import lineIrqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdAck,
  input  srcEvt_t     srcEvt,
  output ctrlStrobe_t strobe,
  output logic        irqOut
);

  logic anyEvt;

  assign anyEvt = srcEvt.pinChg | srcEvt.meterRise | srcEvt.rampRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irqOut <= 1'b1;
    else if (anyEvt) irqOut <= 1'b1;
    else if (rdAck)  irqOut <= 1'b0;
  end

  always_comb begin
    strobe.clearRst = rdAck;
  end

  // A level interrupt holds until acknowledged
  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !rdAck) |=> irqOut);

  // An event that collides with the acknowledge is not lost
  assert_evt_wins_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && anyEvt) |=> irqOut);

  // A quiet acknowledge drops the interrupt
  assert_ack_drops_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && !anyEvt) |=> !irqOut);

endmodule

// File: rtl/lineIrqStatus.sv
module lineIrqStatus
  import lineIrqPkg::*;
#(
  parameter int PIN_COUNT   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int STATUS_W   = PIN_COUNT + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] pinMask,
  input  logic                 meterDone,
  input  logic                 meterAbove,
  input  logic                 rampReady,
  input  logic                 rampStart,
  input  logic                 rdAck,
  output logic [STATUS_W-1:0]  statusOut,
  output logic                 irqOut
);

  srcEvt_t     srcEvt;
  ctrlStrobe_t strobe;

  lineIrqDatapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinMask    (pinMask),
    .meterDone  (meterDone),
    .meterAbove (meterAbove),
    .rampReady  (rampReady),
    .rampStart  (rampStart),
    .strobe     (strobe),
    .srcEvt     (srcEvt),
    .statusWord (statusOut)
  );

  lineIrqControl i_control (
    .clk    (clk),
    .rstN   (rstN),
    .rdAck  (rdAck),
    .srcEvt (srcEvt),
    .strobe (strobe),
    .irqOut (irqOut)
  );

  // A metering-done rise raises the interrupt at the same edge
  assert_meter_rise_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[PIN_COUNT]) |-> irqOut);

endmodule

// File: tb/test_lineIrqStatus.sv
module test_lineIrqStatus;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] pinIn, pinMask;
  logic       meterDone, meterAbove, rampReady, rampStart, rdAck;
  logic [7:0] statusOut;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements
  logic [3:0] mS1, mS2;
  logic mMeter, mThr, mRamp, mRst, mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineIrqStatus i_lineIrqStatus (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinMask(pinMask),
    .meterDone(meterDone), .meterAbove(meterAbove),
    .rampReady(rampReady), .rampStart(rampStart), .rdAck(rdAck),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  function automatic logic evtNow(logic [3:0] s1, logic [3:0] s2, logic [3:0] msk,
                                  logic md, logic mb, logic rn, logic rb);
    return (|((s1 ^ s2) & ~msk)) | (md & ~mb) | (rn & ~rb);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mMeter = 0; mThr = 0; mRamp = 0; mRst = 1; mIrq = 1;
    end else begin
      logic rn, ev;
      rn = rampReady & ~rampStart;
      ev = evtNow(mS1, mS2, pinMask, meterDone, mMeter, rn, mRamp);
      mIrq   = ev | (mIrq & ~rdAck);
      mRst   = mRst & ~rdAck;
      mS2    = mS1;
      mS1    = pinIn;
      mMeter = meterDone;
      mThr   = meterAbove;
      mRamp  = rn;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkModel();
    chk("R5 pins",      32'(statusOut[3:0]), 32'(mS2));
    chk("R3 meter",     32'(statusOut[4]),   32'(mMeter));
    chk("R7 rstflag",   32'(statusOut[5]),   32'(mRst));
    chk("R4 ramp",      32'(statusOut[6]),   32'(mRamp));
    chk("R2 threshold", 32'(statusOut[7]),   32'(mThr));
    chk("R9 irq",       32'(irqOut),         32'(mIrq));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ack();
    rdAck = 1'b1; tick(); rdAck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(SEED);
    rstN = 1'b0; pinIn = '0; pinMask = '0; meterDone = 0; meterAbove = 0;
    rampReady = 0; rampStart = 0; rdAck = 0;
    tick(); tick();
    chk("R1 status in reset", 32'(statusOut), 32'h20);
    chk("R1 irq in reset", 32'(irqOut), 32'd1);
    rstN = 1'b1;
    tick();
    chk("R1 status after reset", 32'(statusOut), 32'h20);
    chk("R1 irq after reset", 32'(irqOut), 32'd1);

    // R7: quiet acknowledge
    ack();
    chk("R7 irq cleared", 32'(irqOut), 32'd0);
    chk("R7 rst flag cleared", 32'(statusOut[5]), 32'd0);

    // R3: rise interrupts, fall does not
    meterDone = 1; tick();
    chk("R3 meter bit", 32'(statusOut[4]), 32'd1);
    chk("R3 rise irq", 32'(irqOut), 32'd1);
    ack();
    meterDone = 0; tick();
    chk("R3 fall no irq", 32'(irqOut), 32'd0);

    // R2: threshold never interrupts
    meterAbove = 1; tick();
    chk("R2 above", 32'(statusOut[7]), 32'd1);
    chk("R2 no irq", 32'(irqOut), 32'd0);
    meterAbove = 0; tick();
    chk("R2 below", 32'(statusOut[7]), 32'd0);

    // R5: unmasked pin, two edges of latency
    pinIn = 4'b0001; tick();
    chk("R5 not yet visible", 32'(statusOut[0]), 32'd0);
    chk("R5 no early irq", 32'(irqOut), 32'd0);
    tick();
    chk("R5 pin visible", 32'(statusOut[0]), 32'd1);
    chk("R5 pin irq", 32'(irqOut), 32'd1);
    ack();
    pinIn = 4'b0000; tick(); tick();
    chk("R5 falling pin irq", 32'(irqOut), 32'd1);
    ack();

    // R6: masked pin updates but stays quiet
    pinMask = 4'b0010; pinIn = 4'b0010; tick(); tick(); tick();
    chk("R6 masked pin visible", 32'(statusOut[1]), 32'd1);
    chk("R6 masked pin no irq", 32'(irqOut), 32'd0);
    pinIn = 4'b0000; tick(); tick(); tick();
    chk("R6 masked fall no irq", 32'(irqOut), 32'd0);
    pinMask = 4'b0000;

    // R4: start forces ready low, rise interrupts
    rampReady = 1; rampStart = 1; tick();
    chk("R4 start holds low", 32'(statusOut[6]), 32'd0);
    chk("R4 no irq under start", 32'(irqOut), 32'd0);
    rampStart = 0; tick();
    chk("R4 ready set", 32'(statusOut[6]), 32'd1);
    chk("R4 ready irq", 32'(irqOut), 32'd1);
    ack();
    rampStart = 1; tick(); rampStart = 0;
    chk("R4 new start clears", 32'(statusOut[6]), 32'd0);
    tick(); ack();

    // R8: event collides with acknowledge
    chk("R8 precondition", 32'(irqOut), 32'd0);
    meterDone = 1; rdAck = 1; tick(); rdAck = 0;
    chk("R8 irq survives ack", 32'(irqOut), 32'd1);

    // R9: held without acknowledge
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 irq held", 32'(irqOut), 32'd1);
    end
    ack();
    chk("R9 released by ack", 32'(irqOut), 32'd0);
    checkModel();

    // Random phase against the reference model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pinIn = 4'($urandom);
      if ($urandom_range(15) == 0) pinMask = 4'($urandom);
      if ($urandom_range(3) == 0) meterDone = ~meterDone;
      if ($urandom_range(3) == 0) meterAbove = ~meterAbove;
      if ($urandom_range(3) == 0) rampReady = ~rampReady;
      rampStart = ($urandom_range(5) == 0);
      rdAck = ($urandom_range(3) == 0);
      tick();
      checkModel();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule